// File: doc/BRIEF.md
# DSD Bit Clock Generator

This block turns a master clock into the bit clock of a one-bit (DSD) audio output port and registers six DSD data lanes in step with that clock. The master clock runs at either 512 or 768 times the audio frame rate, and the output bit rate is 64, 128 or 256 times the frame rate. The divide ratio is therefore one of 8, 4, 2, 12, 6 or 3. The divide-by-3 case uses both master-clock edges so that the bit clock keeps a 50 % duty cycle.

A presence detector runs from a separate free-running reference clock and watches the master clock. After reset the block reports power-down and keeps its outputs quiet until it has seen a steady run of master-clock edges. If the master clock later stops, the block returns to power-down. A change to either rate select while the block is running is picked up only at the end of the bit-clock period in progress, so the output never carries a shortened pulse.

The selects are expected to be quasi-static and synchronous to the master clock. The reset is active-high and synchronous, and the integrator must present it to each clock domain cleanly.

Top module: `dsd_bclk_gen`

## Requirements
- R1: With `mclk_ratio_i`=0 (512x master clock), `dsd_rate_i` codes 00, 01 and 10 give a bit-clock period of 8, 4 and 2 master-clock periods. The clock is high for the first half of each period.
- R2: With `mclk_ratio_i`=1 (768x master clock), codes 00, 01 and 10 give a bit-clock period of 12, 6 and 3 master-clock periods. For the even ratios the clock is high for the first half of each period.
- R3: In the divide-by-3 case the bit clock is high for 1.5 and low for 1.5 master-clock periods.
- R4: `dsd_rate_i`=11 is reserved. Once it has been taken up, `bclk_o` stays low and all `dsd_o` lanes read 0.
- R5: After reset `pd_o` is 1 and stays 1 while the master clock is absent. It falls only after at least 16 rising master-clock edges, each arriving within the detection window of the one before. The bit clock then starts at the selected ratio.
- R6: If no master-clock edge arrives for WIN_CYC reference cycles (default 8), `pd_o` returns to 1 within a few reference cycles.
- R7: A select change during operation lets the current bit-clock period finish at its old length, and the next period uses the new ratio. No high or low phase of `bclk_o` is shorter than one master-clock period.
- R8: Lane `dsd_o[i]` takes `mod_i[i]` once per bit-clock period, near the falling bit-clock edge, and holds it until the next falling edge. Even indices are the left channel of pair i/2 and odd indices are the right channel.
- R9: While reset is held and right after it, `bclk_o` is 0, every `dsd_o` lane is 0 and `pd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for presence detection |
| mclk | input | 1 | Master clock, may be absent |
| rst | input | 1 | Synchronous active-high reset |
| mclk_ratio_i | input | 1 | 0 = 512x master clock, 1 = 768x |
| dsd_rate_i | input | 2 | 00 = 64x, 01 = 128x, 10 = 256x, 11 reserved |
| mod_i | input | LANES | One-bit modulator streams, left/right interleaved |
| bclk_o | output | 1 | Generated DSD bit clock |
| dsd_o | output | LANES | Registered DSD lanes |
| pd_o | output | 1 | Power-down status, 1 while the master clock is not confirmed |

## Verification
On every cycle, assertions check four things: the divider count stays inside the loaded ratio, a new ratio is loaded only at a period boundary, the clock is low while idle or reserved, and lanes change only on a strobe or a clear. Another assertion confirms that power-down can clear only once the edge count is complete. Only the bench scenarios show real edge timing: the measured periods and duty cycles, including the half-cycle phases of the divide-by-3 case, and the minimum pulse width across select changes. The same holds for the delay from a missing or returning master clock to `pd_o`, and for the lane values under random data.

// File: rtl/dbg_pkg.sv
`timescale 1ns/1ps
package dbg_pkg;
  localparam int DIV_W = 4;

  // Divide ratio for a ratio/rate pair; zero marks the reserved rate code.
  function automatic logic [DIV_W-1:0] div_ratio(input logic hi_ratio,
                                                 input logic [1:0] rate);
    logic [DIV_W-1:0] base;
    base = hi_ratio ? DIV_W'(12) : DIV_W'(8);
    case (rate)
      2'b00:   return base;
      2'b01:   return base >> 1;
      2'b10:   return base >> 2;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/dbg_presence.sv
`timescale 1ns/1ps
module dbg_presence #(
  parameter int PRES_EDGES = 16,
  parameter int WIN_CYC    = 8
) (
  input  logic ref_clk,
  input  logic mclk,
  input  logic rst,
  output logic pd_o
);
  localparam int ECW = $clog2(PRES_EDGES + 1);
  localparam int WCW = $clog2(WIN_CYC + 1);
  localparam logic [ECW-1:0] FULL_V = ECW'(PRES_EDGES);
  localparam logic [WCW-1:0] LAST_V = WCW'(WIN_CYC - 1);

  logic           tog;
  logic [2:0]     sh;
  logic [ECW-1:0] ecnt;
  logic [WCW-1:0] wcnt;
  logic           pd_q;
  logic           seen;

  // Toggle flop in the master-clock domain: one flip per rising edge.
  always_ff @(posedge mclk) begin
    if (rst) tog <= 1'b0;
    else     tog <= ~tog;
  end

  assign seen = sh[2] ^ sh[1];

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      sh   <= '0;
      ecnt <= '0;
      wcnt <= '0;
      pd_q <= 1'b1;
    end else begin
      sh <= {sh[1:0], tog};
      if (seen) begin
        wcnt <= '0;
        if (ecnt != FULL_V) ecnt <= ecnt + 1'b1;
      end else if (wcnt == LAST_V) begin
        ecnt <= '0;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
      pd_q <= (ecnt != FULL_V);
    end
  end

  assign pd_o = pd_q;

  // R5: power-down clears only after the full edge count was reached
  a_r5_release_after_edges: assert property (@(posedge ref_clk) disable iff (rst)
    $fell(pd_q) |-> ($past(ecnt) == FULL_V));

  a_r5_count_bounded: assert property (@(posedge ref_clk) disable iff (rst)
    ecnt <= FULL_V);
endmodule

// File: rtl/dbg_divider.sv
`timescale 1ns/1ps
module dbg_divider
  import dbg_pkg::*;
(
  input  logic       mclk,
  input  logic       rst,
  input  logic       run,
  input  logic       ratio_sel,
  input  logic [1:0] rate_sel,
  output logic       bclk_o,
  output logic       stb_o,
  output logic       clr_o
);
  logic [DIV_W-1:0] cur_n, cnt, n_nx, cnt_nx, half, sel_n;
  logic             wrap, odd, e_q, p_q, n_q;

  assign sel_n  = div_ratio(ratio_sel, rate_sel);
  // A new ratio is taken only when the current period is complete (or idle).
  assign wrap   = (cur_n == '0) || (cnt == cur_n - 1'b1);
  assign n_nx   = wrap ? sel_n : cur_n;
  assign cnt_nx = wrap ? '0 : cnt + 1'b1;
  assign half   = n_nx >> 1;
  assign odd    = (n_nx == DIV_W'(3));

  // Lanes load at the falling edge of even ratios, half a cycle after it for /3.
  assign stb_o = run && (odd ? (cnt_nx == DIV_W'(2))
                             : ((n_nx != '0) && (cnt_nx == half)));
  assign clr_o = !run || (n_nx == '0);

  always_ff @(posedge mclk) begin
    if (rst || !run) begin
      cur_n <= '0;
      cnt   <= '0;
      e_q   <= 1'b0;
      p_q   <= 1'b0;
    end else begin
      cur_n <= n_nx;
      cnt   <= cnt_nx;
      e_q   <= (n_nx != '0) && !odd && (cnt_nx < half);
      p_q   <= odd && (cnt_nx == '0);
    end
  end

  // Falling-edge copy stretches the /3 high phase by half a master period.
  always_ff @(negedge mclk) begin
    if (rst) n_q <= 1'b0;
    else     n_q <= p_q;
  end

  assign bclk_o = e_q | p_q | n_q;

  a_r2_cnt_in_range: assert property (@(posedge mclk) disable iff (rst)
    (cur_n != '0) |-> (cnt < cur_n));

  a_r7_switch_at_boundary: assert property (@(posedge mclk) disable iff (rst)
    (cur_n != $past(cur_n)) |->
      ($past(rst) || !$past(run) || ($past(cur_n) == '0) ||
       ($past(cnt) == $past(cur_n) - 1'b1)));

  a_r4_reserved_quiet: assert property (@(posedge mclk) disable iff (rst)
    (cur_n == '0) |-> (!e_q && !p_q));

  a_r9_idle_low: assert property (@(posedge mclk) disable iff (rst)
    !run |=> !bclk_o);
endmodule

// File: rtl/dbg_lanes.sv
`timescale 1ns/1ps
module dbg_lanes #(
  parameter int LANES = 6
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic             stb,
  input  logic             clr,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] dout
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge mclk) begin
      if (rst || clr) dout[g] <= 1'b0;
      else if (stb)   dout[g] <= din[g];
    end
  end

  // R8: lanes move only on a load strobe, a clear or reset
  a_r8_hold_between_strobes: assert property (@(posedge mclk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(rst) || $past(stb) || $past(clr)));
endmodule

// File: rtl/dsd_bclk_gen.sv
`timescale 1ns/1ps
module dsd_bclk_gen #(
  parameter int LANES      = 6,
  parameter int PRES_EDGES = 16,
  parameter int WIN_CYC    = 8
) (
  input  logic             ref_clk,
  input  logic             mclk,
  input  logic             rst,
  input  logic             mclk_ratio_i,
  input  logic [1:0]       dsd_rate_i,
  input  logic [LANES-1:0] mod_i,
  output logic             bclk_o,
  output logic [LANES-1:0] dsd_o,
  output logic             pd_o
);
  logic       pd_ref;
  logic [1:0] run_q;
  logic       stb, clr;

  dbg_presence #(.PRES_EDGES(PRES_EDGES), .WIN_CYC(WIN_CYC)) u_pres (
    .ref_clk (ref_clk),
    .mclk    (mclk),
    .rst     (rst),
    .pd_o    (pd_ref)
  );

  // Carry "clock confirmed" into the master-clock domain.
  always_ff @(posedge mclk) begin
    if (rst) run_q <= '0;
    else     run_q <= {run_q[0], ~pd_ref};
  end

  dbg_divider u_div (
    .mclk      (mclk),
    .rst       (rst),
    .run       (run_q[1]),
    .ratio_sel (mclk_ratio_i),
    .rate_sel  (dsd_rate_i),
    .bclk_o    (bclk_o),
    .stb_o     (stb),
    .clr_o     (clr)
  );

  dbg_lanes #(.LANES(LANES)) u_lanes (
    .mclk (mclk),
    .rst  (rst),
    .stb  (stb),
    .clr  (clr),
    .din  (mod_i),
    .dout (dsd_o)
  );

  assign pd_o = pd_ref;
endmodule

// File: tb/dsd_bclk_gen_tb_top.sv
`timescale 1ns/1ps
module dsd_bclk_gen_tb_top;
  localparam int  LANES   = 6;
  localparam int  WIN_CYC = 8;
  localparam real MCLK_T  = 60.0;

  logic             ref_clk = 1'b0;
  logic             mclk = 1'b0;
  logic             mclk_en;
  logic             rst;
  logic             ratio;
  logic [1:0]       rate;
  logic [LANES-1:0] mod;
  logic             bclk;
  logic [LANES-1:0] dsd;
  logic             pd;

  int checks = 0;
  int fails  = 0;
  int mcnt   = 0;
  int viol   = 0;
  bit mon_en = 1'b0;
  realtime last_edge = 0.0;

  dsd_bclk_gen #(.LANES(LANES), .WIN_CYC(WIN_CYC)) dut_i (
    .ref_clk (ref_clk), .mclk (mclk), .rst (rst),
    .mclk_ratio_i (ratio), .dsd_rate_i (rate), .mod_i (mod),
    .bclk_o (bclk), .dsd_o (dsd), .pd_o (pd)
  );

  always #10 ref_clk = ~ref_clk;
  always #30 if (mclk_en) mclk = ~mclk;
  always @(posedge mclk) mcnt++;

  // Minimum pulse monitor (R7)
  always @(bclk) begin
    if (mon_en && ($realtime - last_edge) < MCLK_T - 0.5) viol++;
    last_edge = $realtime;
  end

  function automatic int exp_div(input logic r, input logic [1:0] s);
    int b;
    b = r ? 12 : 8;
    return (s == 2'b11) ? 0 : (b >> s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic measure(output int per, output int hi);
    realtime t0, t1, t2;
    @(posedge bclk); t0 = $realtime;
    @(negedge bclk); t1 = $realtime;
    @(posedge bclk); t2 = $realtime;
    per = int'(t2 - t0);
    hi  = int'(t1 - t0);
  endtask

  task automatic apply(input logic r, input logic [1:0] s);
    @(negedge mclk);
    ratio = r; rate = s;
    repeat (2) @(posedge bclk);
  endtask

  task automatic check_ratio(input logic r, input logic [1:0] s);
    int per, hi, n;
    string req;
    n = exp_div(r, s);
    req = (n == 3) ? "R3" : (r ? "R2" : "R1");
    measure(per, hi);
    chk(per == int'(n * MCLK_T), req, per, int'(n * MCLK_T));
    chk(hi == int'(n * MCLK_T / 2.0), req, hi, int'(n * MCLK_T / 2.0));
  endtask

  task automatic lane_run(input int n);
    logic [LANES-1:0] exp_l;
    exp_l = '0;
    for (int i = 0; i < n; i++) begin
      @(posedge bclk);
      #1;
      if (i > 0) chk(dsd == exp_l, "R8", int'(dsd), int'(exp_l));
      #4;
      mod = LANES'($urandom);
      exp_l = mod;
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int n0, k, per, hi;
    bit ok;
    realtime tr;
    void'($urandom(32'd20240611));
    rst = 1'b1; mclk_en = 1'b1; ratio = 1'b0; rate = 2'b00; mod = '0;
    repeat (12) @(negedge ref_clk);
    mclk_en = 1'b0;
    repeat (4) @(negedge ref_clk);
    chk(pd == 1'b1 && bclk == 1'b0 && dsd == '0, "R9", int'({pd, bclk}), 2);
    rst = 1'b0;
    repeat (2) @(negedge ref_clk);
    chk(pd == 1'b1, "R9", int'(pd), 1);
    chk(bclk == 1'b0 && dsd == '0, "R9", int'(dsd), 0);

    // No master clock: power-down must persist
    repeat (40) @(negedge ref_clk);
    chk(pd == 1'b1, "R5", int'(pd), 1);

    // Start master clock, count edges until release
    n0 = mcnt;
    mclk_en = 1'b1;
    k = 0;
    while (pd && k < 400) begin @(negedge ref_clk); k++; end
    chk((mcnt - n0) >= 16 && (mcnt - n0) <= 18, "R5", mcnt - n0, 16);
    repeat (4) @(negedge mclk);
    mon_en = 1'b1;

    // Directed sweep of all valid ratio pairs with lane checks
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 3; s++) begin
        apply(r[0], s[1:0]);
        check_ratio(r[0], s[1:0]);
        lane_run(4);
      end
    end

    // Random valid combinations
    for (int i = 0; i < 6; i++) begin
      logic       rr;
      logic [1:0] ss;
      rr = 1'($urandom);
      ss = 2'($urandom_range(0, 2));
      apply(rr, ss);
      check_ratio(rr, ss);
      lane_run(3);
    end

    // R7: switch from /12 to /2 mid-period
    apply(1'b1, 2'b00);
    @(posedge bclk); tr = $realtime;
    k = $urandom_range(1, 10);
    repeat (k) @(negedge mclk);
    ratio = 1'b0; rate = 2'b10;
    @(posedge bclk);
    chk(int'($realtime - tr) == int'(12 * MCLK_T), "R7", int'($realtime - tr), int'(12 * MCLK_T));
    measure(per, hi);
    chk(per == int'(2 * MCLK_T), "R7", per, int'(2 * MCLK_T));

    // R4: reserved rate code
    @(negedge mclk); rate = 2'b11;
    repeat (30) @(negedge mclk);
    ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge ref_clk);
      if (bclk !== 1'b0 || dsd !== '0) ok = 1'b0;
      mod = LANES'($urandom);
    end
    chk(ok, "R4", int'({bclk, dsd}), 0);
    chk(pd == 1'b0, "R4", int'(pd), 0);

    // R6: master clock loss and recovery
    apply(1'b1, 2'b01);
    check_ratio(1'b1, 2'b01);
    chk(viol == 0, "R7", viol, 0);
    mon_en = 1'b0;
    @(negedge mclk); mclk_en = 1'b0;
    k = 0;
    while (!pd && k < 60) begin @(negedge ref_clk); k++; end
    chk(pd == 1'b1 && k <= WIN_CYC + 8, "R6", k, WIN_CYC);
    repeat (10) @(negedge ref_clk);
    mclk_en = 1'b1;
    k = 0;
    while (pd && k < 400) begin @(negedge ref_clk); k++; end
    chk(pd == 1'b0, "R5", int'(pd), 0);
    repeat (6) @(negedge mclk);
    repeat (2) @(posedge bclk);
    check_ratio(1'b1, 2'b01);

    summary();
    $finish;
  end
endmodule